// File: doc/BRIEF.md
# Shared Inter-Core Mailbox Slot Array

This block is a bank of message slots that two processor cores use to pass short fixed-length messages. Each slot has one control word and a row of data words. A sender puts a slot into the transmitting state, writes its data words, and the write of the last word sends a one-cycle doorbell pulse for that slot to the peer's interrupt block. The peer reads the message and then asserts that slot's acknowledge input.

Each slot has an acknowledge-style bit. In automatic style the slot goes back to idle by itself when the acknowledge arrives, and the sender finds out by polling the state field. In interrupt style the slot moves to the acknowledged state and sends a one-cycle event pulse toward the sender. Software reaches every slot through a single-cycle register bus. Read data is registered.

Top module: `ipc_mailbox_regs`

## Requirements
- R1: After reset, every slot's control word reads 0x00000010 (state idle, style bit 0), every data word reads zero, and no event output is high.
- R2: Slot n starts at byte address 0x40*n. Its control word at slot offset 0x0 holds the one-hot state in bits 7:4 (0x1 idle, 0x2 transmitting, 0x4 receiving, 0x8 acknowledged) and the acknowledge style in bit 0 (1 automatic, 0 interrupt). All other bits read zero, and a write stores both fields.
- R3: A control-word write whose state field is not one-hot leaves the state unchanged. The style bit from the same write is still stored.
- R4: Data word k (k = 1..8) of slot n sits at slot offset 4*k. Each word reads back exactly what was last written to it, and writes to one slot do not touch any other slot.
- R5: A write to a slot offset that is not word-aligned, or whose word index is above 8, changes nothing. A read of such an offset returns zero.
- R6: Read data appears on the first clock edge after the read request and holds until the next read.
- R7: An acknowledge to a transmitting slot in automatic style returns the state to idle and gives no acknowledge event.
- R8: An acknowledge to a transmitting slot in interrupt style sets the state to acknowledged and raises that slot's acknowledge event for exactly one cycle.
- R9: An acknowledge to a slot that is not transmitting has no effect on its state and gives no event.
- R10: A write to data word 8 of a transmitting slot raises that slot's doorbell event for one cycle. The same write to a slot in any other state gives no doorbell.
- R11: When a control-word write and an acknowledge hit the same slot in the same cycle, the state follows the acknowledge, judged with the style bit held before the write, and the style bit takes the written value.
- R12: A read issued in the same cycle as an acknowledge returns the value the slot held before that acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Bus request strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 11 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| peer_ack | input | 32 | Per-slot acknowledge from the peer |
| ack_evt | output | 32 | Per-slot acknowledge event pulse |
| ring_evt | output | 32 | Per-slot doorbell pulse to the peer |

## Verification
Two things can land on the same slot's state in one cycle: a software write to the control word and the peer's acknowledge. The bench drives both in the same cycle on a transmitting slot in interrupt style. The write asks for receiving with automatic style. The result passes if the state reads acknowledged with the style bit set and the acknowledge event fires. A second test drives a read together with an acknowledge and expects the pre-acknowledge value back.

// File: rtl/mbx_pkg.sv
// Package: shared constants and types for the mailbox slot array.
// Assumes the state field is four bits wide and sits at bits 7:4 of the
// control word, with the acknowledge-style bit at bit 0.
package mbx_pkg;

    localparam int STATE_LSB = 4;
    localparam int STATE_W   = 4;
    localparam int STYLE_BIT = 0;

    // One-hot slot transfer state
    typedef enum logic [STATE_W-1:0] {
        ST_IDLE = 4'h1,
        ST_TX   = 4'h2,
        ST_RX   = 4'h4,
        ST_ACK  = 4'h8
    } slot_state_t;

    // True when exactly one bit of a state field is set
    function automatic logic is_onehot(input logic [STATE_W-1:0] v);
        int n;
        n = 0;
        for (int i = 0; i < STATE_W; i++) begin
            n = n + int'(v[i]);
        end
        return (n == 1);
    endfunction

endpackage

// File: rtl/mbx_addr_decode.sv
// Module: splits a byte address into slot number and word position, and
// flags whether the address hits the control word, a data word, or nothing.
// Assumes word-aligned access only; a misaligned or out-of-range offset
// is reported as no hit.
module mbx_addr_decode #(
    parameter int NUM_SLOTS = 32,
    parameter int WORDS     = 8,
    parameter int WIN_BITS  = 6,
    localparam int SB   = $clog2(NUM_SLOTS),
    localparam int WIX  = WIN_BITS - 2,
    localparam int WSEL = $clog2(WORDS),
    localparam int AW   = SB + WIN_BITS
) (
    input  logic [AW-1:0]   addr,
    output logic [SB-1:0]   slot,
    output logic [WSEL-1:0] word,
    output logic            mode_hit,
    output logic            data_hit
);

    logic [WIX-1:0] widx;
    logic           aligned;
    logic           slot_ok;
    logic [WIX-1:0] widx_m1;

    // Field extraction and range checks
    always_comb begin
        slot     = addr[AW-1:WIN_BITS];
        widx     = addr[WIN_BITS-1:2];
        aligned  = (addr[1:0] == 2'b00);
        slot_ok  = (int'(slot) < NUM_SLOTS);
        widx_m1  = widx - WIX'(1);
        word     = widx_m1[WSEL-1:0];
        mode_hit = aligned && slot_ok && (widx == '0);
        data_hit = aligned && slot_ok && (widx != '0) && (int'(widx) <= WORDS);
    end

endmodule

// File: rtl/mbx_slot.sv
// Module: one mailbox slot, holding the transfer state, the acknowledge
// style bit and the data words, plus the acknowledge and doorbell events.
// Assumes at most one bus write per cycle; a peer acknowledge wins over
// a software write for the state field.
module mbx_slot
    import mbx_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int DW    = 32,
    localparam int WSEL = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_mode,
    input  logic            wr_data,
    input  logic [WSEL-1:0] wr_word,
    input  logic [DW-1:0]   wdata,
    input  logic            peer_ack,
    output slot_state_t     state,
    output logic            style_auto,
    output logic [DW-1:0]   words [WORDS],
    output logic            ack_evt,
    output logic            ring_evt
);

    logic                take_ack;
    logic [STATE_W-1:0]  wr_state;
    logic                last_word;

    // Decode of this cycle's requests
    always_comb begin
        take_ack  = peer_ack && (state == ST_TX);
        wr_state  = wdata[STATE_LSB +: STATE_W];
        last_word = (wr_word == WSEL'(WORDS - 1));
    end

    // State, style bit and acknowledge event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            style_auto <= 1'b0;
            ack_evt    <= 1'b0;
        end else begin
            ack_evt <= 1'b0;
            if (wr_mode) begin
                style_auto <= wdata[STYLE_BIT];
            end
            if (take_ack) begin
                state   <= style_auto ? ST_IDLE : ST_ACK;
                ack_evt <= !style_auto;
            end else if (wr_mode && is_onehot(wr_state)) begin
                state <= slot_state_t'(wr_state);
            end
        end
    end

    // Data word storage and doorbell on the last word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                words[i] <= '0;
            end
            ring_evt <= 1'b0;
        end else begin
            ring_evt <= 1'b0;
            if (wr_data) begin
                words[wr_word] <= wdata;
                if (last_word && (state == ST_TX)) begin
                    ring_evt <= 1'b1;
                end
            end
        end
    end

    // R3: the state field stays one-hot
    p_state_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(state));

    // R7: automatic style returns to idle silently
    p_auto_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_ack && (state == ST_TX) && style_auto) |=> ((state == ST_IDLE) && !ack_evt));

    // R8: interrupt style moves to acknowledged with an event
    p_irq_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_ack && (state == ST_TX) && !style_auto) |=> ((state == ST_ACK) && ack_evt));

    // R8: the acknowledge event lasts one cycle
    p_evt_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ack_evt |=> !ack_evt);

    // R9: acknowledge outside transmitting changes nothing
    p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (peer_ack && (state != ST_TX) && !wr_mode) |=> ($stable(state) && !ack_evt));

    // R10: a doorbell only follows a transmitting slot
    p_ring_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ring_evt |-> ($past(state) == ST_TX));

    // R10: the doorbell lasts one cycle
    p_ring_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ring_evt |=> !ring_evt);

endmodule

// File: rtl/mbx_rdmux.sv
// Module: registered read path selecting a slot's control word or a data
// word. Assumes decode flags are mutually exclusive; a miss reads zero.
module mbx_rdmux
    import mbx_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int WORDS     = 8,
    parameter int DW        = 32,
    localparam int SB   = $clog2(NUM_SLOTS),
    localparam int WSEL = $clog2(WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rd_en,
    input  logic            mode_hit,
    input  logic            data_hit,
    input  logic [SB-1:0]   slot,
    input  logic [WSEL-1:0] word,
    input  slot_state_t     states [NUM_SLOTS],
    input  logic            styles [NUM_SLOTS],
    input  logic [DW-1:0]   words  [NUM_SLOTS][WORDS],
    output logic [DW-1:0]   rdata
);

    logic [DW-1:0] mode_word;

    // Assemble the control word of the addressed slot
    always_comb begin
        mode_word = '0;
        mode_word[STATE_LSB +: STATE_W] = states[slot];
        mode_word[STYLE_BIT]            = styles[slot];
    end

    // Capture read data on a read request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (mode_hit) begin
                rdata <= mode_word;
            end else if (data_hit) begin
                rdata <= words[slot][word];
            end else begin
                rdata <= '0;
            end
        end
    end

    // R5: unmapped reads return zero
    p_unmapped_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mode_hit && !data_hit) |=> (rdata == '0));

    // R6: read data holds between reads
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

endmodule

// File: rtl/ipc_mailbox_regs.sv
// Module: top of the mailbox slot array. Decodes the register bus, routes
// write strobes to one slot, collects per-slot event pulses, and returns
// registered read data. Assumes a single-cycle bus with no wait states and
// NUM_SLOTS of at least two.
module ipc_mailbox_regs
    import mbx_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    parameter int WORDS     = 8,
    parameter int DW        = 32,
    parameter int WIN_BITS  = 6,
    localparam int SB   = $clog2(NUM_SLOTS),
    localparam int WSEL = $clog2(WORDS),
    localparam int AW   = SB + WIN_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [DW-1:0]        bus_wdata,
    output logic [DW-1:0]        bus_rdata,
    input  logic [NUM_SLOTS-1:0] peer_ack,
    output logic [NUM_SLOTS-1:0] ack_evt,
    output logic [NUM_SLOTS-1:0] ring_evt
);

    logic [SB-1:0]   dec_slot;
    logic [WSEL-1:0] dec_word;
    logic            dec_mode;
    logic            dec_data;
    logic            wr_go;
    logic            rd_go;

    slot_state_t     st_arr  [NUM_SLOTS];
    logic            sty_arr [NUM_SLOTS];
    logic [DW-1:0]   wd_arr  [NUM_SLOTS][WORDS];

    // Bus request qualifiers
    always_comb begin
        wr_go = bus_en && bus_wr;
        rd_go = bus_en && !bus_wr;
    end

    mbx_addr_decode #(
        .NUM_SLOTS (NUM_SLOTS),
        .WORDS     (WORDS),
        .WIN_BITS  (WIN_BITS)
    ) u_dec (
        .addr     (bus_addr),
        .slot     (dec_slot),
        .word     (dec_word),
        .mode_hit (dec_mode),
        .data_hit (dec_data)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic sel;

        // Slot select from the decoded address
        always_comb sel = (dec_slot == SB'(g));

        mbx_slot #(
            .WORDS (WORDS),
            .DW    (DW)
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_mode    (wr_go && dec_mode && sel),
            .wr_data    (wr_go && dec_data && sel),
            .wr_word    (dec_word),
            .wdata      (bus_wdata),
            .peer_ack   (peer_ack[g]),
            .state      (st_arr[g]),
            .style_auto (sty_arr[g]),
            .words      (wd_arr[g]),
            .ack_evt    (ack_evt[g]),
            .ring_evt   (ring_evt[g])
        );
    end

    mbx_rdmux #(
        .NUM_SLOTS (NUM_SLOTS),
        .WORDS     (WORDS),
        .DW        (DW)
    ) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_go),
        .mode_hit (dec_mode),
        .data_hit (dec_data),
        .slot     (dec_slot),
        .word     (dec_word),
        .states   (st_arr),
        .styles   (sty_arr),
        .words    (wd_arr),
        .rdata    (bus_rdata)
    );

    // R1: event outputs are quiet on the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> ((ack_evt == '0) && (ring_evt == '0)));

    // R11: a control write cannot block a same-cycle acknowledge
    p_ack_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_go && dec_mode && peer_ack[dec_slot] && (st_arr[dec_slot] == ST_TX)
         && !sty_arr[dec_slot]) |=> (ack_evt != '0));

endmodule

// File: tb/sim_ipc_mailbox_regs.sv
`timescale 1ns/1ps
module sim_ipc_mailbox_regs;

    localparam int NS = 32;
    localparam int NV = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [10:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NS-1:0] peer_ack = '0;
    logic [NS-1:0] ack_evt;
    logic [NS-1:0] ring_evt;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] rd;

    always #10 clk = ~clk;

    ipc_mailbox_regs u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .peer_ack  (peer_ack),
        .ack_evt   (ack_evt),
        .ring_evt  (ring_evt)
    );

    // Vector: {is_read, addr, wdata, expected}
    localparam logic [75:0] VEC [NV] = '{
        {1'b1, 11'h000, 32'h0,         32'h00000010}, // R1 control word
        {1'b1, 11'h7C4, 32'h0,         32'h00000000}, // R1 data word
        {1'b0, 11'h044, 32'hA5A50001,  32'h0},
        {1'b0, 11'h060, 32'hDEAD0008,  32'h0},
        {1'b1, 11'h044, 32'h0,         32'hA5A50001}, // R4
        {1'b1, 11'h060, 32'h0,         32'hDEAD0008}, // R4
        {1'b1, 11'h004, 32'h0,         32'h00000000}, // R4 other slot
        {1'b0, 11'h040, 32'hFFFFFF21,  32'h0},
        {1'b1, 11'h040, 32'h0,         32'h00000021}, // R2
        {1'b0, 11'h040, 32'h00000030,  32'h0},
        {1'b1, 11'h040, 32'h0,         32'h00000020}, // R3
        {1'b0, 11'h040, 32'h00000001,  32'h0},
        {1'b1, 11'h040, 32'h0,         32'h00000021}, // R3 zero state
        {1'b0, 11'h064, 32'h00001234,  32'h0},
        {1'b1, 11'h064, 32'h0,         32'h00000000}, // R5
        {1'b0, 11'h046, 32'h00000055,  32'h0},
        {1'b1, 11'h044, 32'h0,         32'hA5A50001}, // R5
        {1'b1, 11'h046, 32'h0,         32'h00000000}  // R5
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [10:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [10:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    // Acknowledge one slot; returns with events sampled one cycle later
    task automatic ack_slot(input int s);
        @(negedge clk);
        peer_ack = '0; peer_ack[s] = 1'b1;
        @(negedge clk);
        peer_ack = '0;
    endtask

    initial begin
        #4000000;
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ack_evt", ack_evt, 32'h0);
        chk("R1 ring_evt", ring_evt, 32'h0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][75]) begin
                bus_read(VEC[i][74:64], rd);
                chk($sformatf("R2/R3/R4/R5 vector %0d", i), rd, VEC[i][31:0]);
            end else begin
                bus_write(VEC[i][74:64], VEC[i][63:32]);
            end
        end

        // R6: read data holds with no request
        bus_read(11'h044, rd);
        @(negedge clk);
        chk("R6 hold", bus_rdata, 32'hA5A50001);

        // R10: doorbell on last word of a transmitting slot (slot 1 is TX)
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 11'h060; bus_wdata = 32'h1;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
        chk("R10 ring", ring_evt, 32'h00000002);
        @(negedge clk);
        chk("R10 ring one cycle", ring_evt, 32'h0);
        // R10: idle slot 2 gives no doorbell
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 11'h0A0; bus_wdata = 32'h2;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
        chk("R10 no ring when idle", ring_evt, 32'h0);

        // R7: slot 1 automatic style
        ack_slot(1);
        chk("R7 no event", ack_evt, 32'h0);
        bus_read(11'h040, rd);
        chk("R7 idle", rd, 32'h00000011);

        // R8: slot 3 interrupt style
        bus_write(11'h0C0, 32'h00000020);
        ack_slot(3);
        chk("R8 event", ack_evt, 32'h00000008);
        @(negedge clk);
        chk("R8 event one cycle", ack_evt, 32'h0);
        bus_read(11'h0C0, rd);
        chk("R8 acknowledged", rd, 32'h00000080);

        // R9: acknowledge while acknowledged or idle
        ack_slot(3);
        chk("R9 no event", ack_evt, 32'h0);
        bus_read(11'h0C0, rd);
        chk("R9 state kept", rd, 32'h00000080);
        ack_slot(0);
        bus_read(11'h000, rd);
        chk("R9 idle kept", rd, 32'h00000010);

        // R11: write and acknowledge together on slot 4
        bus_write(11'h100, 32'h00000020);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 11'h100; bus_wdata = 32'h00000041;
        peer_ack[4] = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0; peer_ack = '0;
        chk("R11 event", ack_evt, 32'h00000010);
        bus_read(11'h100, rd);
        chk("R11 state and style", rd, 32'h00000081);

        // R12: read alongside acknowledge on slot 5
        bus_write(11'h140, 32'h00000021);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = 11'h140;
        peer_ack[5] = 1'b1;
        @(negedge clk);
        bus_en = 1'b0; peer_ack = '0;
        chk("R12 old value", bus_rdata, 32'h00000021);
        bus_read(11'h140, rd);
        chk("R12 new value", rd, 32'h00000011);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule